// File: doc/BRIEF.md
# Memory-Mapped BCD Time-of-Day Clock

This block joins a byte-wide scratch memory and a calendar clock behind one address space. The eight highest byte addresses of the `2^ADDR_W` space do not reach the memory. They select clock registers that hold century, year, month, date, day of week, hours, minutes and seconds, all as packed BCD. Every lower address is ordinary read/write storage. A host uses one select/write-enable/address/data port for both kinds of location. Reads return data one clock after the request.

The clock moves forward by one second on each clock cycle in which the `tick` input is high. One tick cycle carries the value through all fields. Seconds roll into minutes, minutes into hours, hours into the next date and the next weekday. Dates roll into months according to each month's length, with February at 29 days in leap years. Months roll into years, and year 99 rolls into the next century.

A host write to a clock register lands at the clock edge that samples it. If a tick is present in that same cycle, the tick is applied on top of the written value. The default map has 1 KiB. Setting `ADDR_W` to 13 gives an 8 KiB map whose clock sits at 0x1FF8 to 0x1FFF.

Top module: `bcd_rtc_mem`

## Requirements
- R1: Addresses whose bits `[ADDR_W-1:3]` are all ones select the clock. Offset `addr[2:0]` picks the register: 0 century, 1 year, 2 month, 3 date, 4 day of week, 5 hours, 6 minutes, 7 seconds. Every other address is plain byte memory. A memory write never alters the clock, and a clock write never alters memory.
- R2: A read request (`sel`=1, `we`=0) presents its byte on `rdata` after the next rising clock edge. `rdata` then holds until the next read request. A clock read returns the register value from before that edge.
- R3: After reset the clock reads century 0x20 (parameter `RST_CENTURY`), year 0x00, month 0x01, date 0x01, day 0x01, and hours, minutes and seconds 0x00.
- R4: Seconds and minutes count in BCD from 0x00 to 0x59. A units digit of 9 carries into the tens digit. 0x59 wraps to 0x00 and carries into the next field.
- R5: Hours count from 0x00 to 0x23. 0x23 wraps to 0x00 and advances the date by one day.
- R6: Day of week counts 1 to 7. It advances on every date advance, and 7 wraps to 1.
- R7: After the last day of a month the date goes to 0x01 and the month advances. April, June, September and November end at 0x30, the other months except February end at 0x31, and month 0x12 wraps to 0x01 and advances the year.
- R8: February ends at 0x29 when the year is a leap year and at 0x28 otherwise. With `LEAP_FULL`=1 the test uses the four-digit year: divisible by 4 and not by 100, or divisible by 400. For example, 2000 and 2024 are leap years and 1900, 2023 and 2100 are not.
- R9: Year 0x99 wraps to 0x00 and advances the century. Century 0x99 wraps to 0x00.
- R10: A clock register write takes effect at the edge that samples it. A tick in the same cycle advances the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read (qualified by `sel`) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read request |
| tick | input | 1 | One-second advance pulse |

## Verification
A wrong carry decision inside the clock is visible at the ports only when the host reads the affected field. It then shows as a wrong digit in the very next read, one clock after the tick. For this reason every table vector parks the clock just before a boundary, applies a single tick and reads all eight fields back. This exposes a wrong cascade into more distant fields at once, not only the field that wrapped. Faults in address decoding or write staging corrupt either a memory byte or a clock field that a later read returns. The bench therefore reads both kinds of location after writing the other.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef logic [7:0] bcd8_t;
   typedef bcd8_t [7:0] rtc_file_t;

   localparam int unsigned F_CEN  = 0;
   localparam int unsigned F_YEAR = 1;
   localparam int unsigned F_MON  = 2;
   localparam int unsigned F_DATE = 3;
   localparam int unsigned F_DOW  = 4;
   localparam int unsigned F_HOUR = 5;
   localparam int unsigned F_MIN  = 6;
   localparam int unsigned F_SEC  = 7;

   // increment one packed-BCD byte (caller handles the field wrap)
   function automatic bcd8_t bcd_inc(input bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input bcd8_t v);
      return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
   endfunction

   // last day of a month, as BCD
   function automatic bcd8_t month_end(input bcd8_t mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
   parameter int unsigned AW = 10
) (
   input  logic          clk,
   input  logic          wr,
   input  logic          rd,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wd,
   output logic [7:0]    rq
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr) mem[addr] <= wd;
      if (rd) rq <= mem[addr];
   end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_pkg::*;
#(
   parameter bcd8_t RST_CENTURY = 8'h20,
   parameter bit    LEAP_FULL   = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic [2:0] wr_idx,
   input  bcd8_t     wr_data,
   input  logic      tick,
   output rtc_file_t tfile
);
   // packed order: index 7 (seconds) leftmost
   localparam rtc_file_t RST_FILE =
      {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, RST_CENTURY};

   rtc_file_t file_q, staged, file_d;
   logic      leap;

   // host write lands first
   always_comb begin
      staged = file_q;
      if (wr_en) staged[wr_idx] = wr_data;
   end

   generate
      if (LEAP_FULL) begin : g_leap_full
         logic [6:0] yb, cb;
         assign yb   = bcd_to_bin(staged[F_YEAR]);
         assign cb   = bcd_to_bin(staged[F_CEN]);
         assign leap = (staged[F_YEAR] == 8'h00) ? (cb[1:0] == 2'b00)
                                                 : (yb[1:0] == 2'b00);
      end else begin : g_leap_simple
         logic [6:0] yb;
         assign yb   = bcd_to_bin(staged[F_YEAR]);
         assign leap = (yb[1:0] == 2'b00);
      end
   endgenerate

   // then the tick ripples through the whole calendar in one cycle
   always_comb begin
      file_d = staged;
      if (tick) begin
         if (staged[F_SEC] < 8'h59) file_d[F_SEC] = bcd_inc(staged[F_SEC]);
         else begin
            file_d[F_SEC] = 8'h00;
            if (staged[F_MIN] < 8'h59) file_d[F_MIN] = bcd_inc(staged[F_MIN]);
            else begin
               file_d[F_MIN] = 8'h00;
               if (staged[F_HOUR] < 8'h23) file_d[F_HOUR] = bcd_inc(staged[F_HOUR]);
               else begin
                  file_d[F_HOUR] = 8'h00;
                  file_d[F_DOW]  = (staged[F_DOW] >= 8'h07) ? 8'h01
                                                            : bcd_inc(staged[F_DOW]);
                  if (staged[F_DATE] < month_end(staged[F_MON], leap))
                     file_d[F_DATE] = bcd_inc(staged[F_DATE]);
                  else begin
                     file_d[F_DATE] = 8'h01;
                     if (staged[F_MON] < 8'h12) file_d[F_MON] = bcd_inc(staged[F_MON]);
                     else begin
                        file_d[F_MON] = 8'h01;
                        if (staged[F_YEAR] < 8'h99) file_d[F_YEAR] = bcd_inc(staged[F_YEAR]);
                        else begin
                           file_d[F_YEAR] = 8'h00;
                           file_d[F_CEN]  = (staged[F_CEN] >= 8'h99) ? 8'h00
                                                                     : bcd_inc(staged[F_CEN]);
                        end
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) file_q <= RST_FILE;
      else        file_q <= file_d;
   end

   assign tfile = file_q;
endmodule

// File: rtl/bcd_rtc_mem.sv
module bcd_rtc_mem
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter bcd8_t       RST_CENTURY = 8'h20,
   parameter bit          LEAP_FULL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              tick
);
   generate
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_aw
         $error("bcd_rtc_mem: ADDR_W must lie in 4..16");
      end
      if (RST_CENTURY[3:0] > 4'd9 || RST_CENTURY[7:4] > 4'd9) begin : g_bad_cen
         $error("bcd_rtc_mem: RST_CENTURY must be packed BCD");
      end
   endgenerate

   logic      in_clock, rd_req;
   logic      clk_sel_q;
   bcd8_t     clk_byte_q;
   logic [7:0] ram_q;
   rtc_file_t time_file;

   assign in_clock = &addr[ADDR_W-1:3];
   assign rd_req   = sel & ~we;

   rtc_byte_ram #(.AW(ADDR_W)) u_ram (
      .clk  (clk),
      .wr   (sel & we & ~in_clock),
      .rd   (rd_req & ~in_clock),
      .addr (addr),
      .wd   (wdata),
      .rq   (ram_q)
   );

   rtc_time_core #(.RST_CENTURY(RST_CENTURY), .LEAP_FULL(LEAP_FULL)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel & we & in_clock),
      .wr_idx  (addr[2:0]),
      .wr_data (wdata),
      .tick    (tick),
      .tfile   (time_file)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sel_q  <= 1'b0;
         clk_byte_q <= 8'h00;
      end else if (rd_req) begin
         clk_sel_q  <= in_clock;
         clk_byte_q <= time_file[addr[2:0]];
      end
   end

   assign rdata = clk_sel_q ? clk_byte_q : ram_q;
endmodule

// File: rtl/bcd_rtc_mem_chk.sv
module bcd_rtc_mem_chk
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              tick,
   input rtc_file_t         tfile
);
   logic       clk_wr;
   logic [2:0] off;
   assign clk_wr = sel & we & (&addr[ADDR_W-1:3]);
   assign off    = addr[2:0];

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clk_wr) |=> $stable(tfile));

   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && !we) |=> $stable(rdata));

   // R4
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clk_wr && tfile[F_SEC] == 8'h59) |=>
         (tfile[F_SEC] == 8'h00 && tfile[F_MIN] != $past(tfile[F_MIN])));

   // R5
   hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tfile[F_HOUR] <= 8'h23);

   // R6
   dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tfile[F_DOW] >= 8'h01 && tfile[F_DOW] <= 8'h07));

   // R9
   century_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clk_wr && tfile[F_YEAR] == 8'h99 && tfile[F_MON] == 8'h12 &&
       tfile[F_DATE] == 8'h31 && tfile[F_HOUR] == 8'h23 &&
       tfile[F_MIN] == 8'h59 && tfile[F_SEC] == 8'h59) |=>
         (tfile[F_YEAR] == 8'h00 && tfile[F_CEN] != $past(tfile[F_CEN])));

   // R10
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_wr && !tick) |=> (tfile[$past(off)] == $past(wdata)));
endmodule

bind bcd_rtc_mem bcd_rtc_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .sel   (sel),
   .we    (we),
   .addr  (addr),
   .wdata (wdata),
   .rdata (rdata),
   .tick  (tick),
   .tfile (time_file)
);

// File: tb/bcd_rtc_mem_bench.sv
`timescale 1ns/1ps
module bcd_rtc_mem_bench;
   localparam int unsigned AW   = 10;
   localparam logic [AW-1:0] BASE = {{(AW-3){1'b1}}, 3'b000};
   localparam int NV = 18;

   // packed as {cen, year, mon, date, dow, hour, min, sec}
   localparam logic [63:0] VIN [NV] = '{
      64'h20240315_03102030, 64'h20240315_03102059, 64'h20240315_03105959,
      64'h20240315_03235959, 64'h20240315_07235959, 64'h20230430_02235959,
      64'h20230530_02235959, 64'h20231231_06235959, 64'h20230228_02235959,
      64'h20240228_03235959, 64'h20240229_04235959, 64'h19000228_01235959,
      64'h20000228_01235959, 64'h21000228_01235959, 64'h19991231_05235959,
      64'h99991231_05235959, 64'h20240309_02235959, 64'h20240309_02120959};
   localparam logic [63:0] VEXP [NV] = '{
      64'h20240315_03102031, 64'h20240315_03102100, 64'h20240315_03110000,
      64'h20240316_04000000, 64'h20240316_01000000, 64'h20230501_03000000,
      64'h20230531_03000000, 64'h20240101_07000000, 64'h20230301_03000000,
      64'h20240229_04000000, 64'h20240301_05000000, 64'h19000301_02000000,
      64'h20000229_02000000, 64'h21000301_02000000, 64'h20000101_06000000,
      64'h00000101_06000000, 64'h20240310_03000000, 64'h20240309_02121000};
   // requirement each vector targets: R4 R5 R6 R7 R8 R9
   localparam int VREQ [NV] = '{4, 4, 4, 5, 6, 7, 7, 7, 8, 8, 8, 8, 8, 8, 9, 9, 5, 4};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0, we = 1'b0, tick = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   bcd_rtc_mem #(.ADDR_W(AW)) u_bcd_rtc_mem (
      .clk(clk), .rst_n(rst_n), .sel(sel), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic t);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick = t;
      @(negedge clk);
      sel = 1'b0; we = 1'b0; tick = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic pulse;
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 reset contents, read through the host port
      begin
         logic [63:0] rst_exp;
         rst_exp = 64'h20000101_01000000;
         for (int k = 0; k < 8; k++) begin
            rd(BASE + AW'(k), v);
            chk($sformatf("R3 reset offset %0d", k), v, rst_exp[63-8*k -: 8]);
         end
      end

      // R1 plain memory below the clock, including the last byte
      wr(AW'(0), 8'h3C, 1'b0);
      wr(BASE - AW'(1), 8'hA5, 1'b0);
      rd(AW'(0), v);           chk("R1 ram low byte", v, 8'h3C);
      rd(BASE - AW'(1), v);    chk("R1 ram top byte", v, 8'hA5);
      wr(BASE + AW'(7), 8'h42, 1'b0);
      rd(BASE - AW'(1), v);    chk("R1 clock write leaves ram", v, 8'hA5);
      rd(BASE + AW'(7), v);    chk("R10 clock write lands", v, 8'h42);
      wr(BASE - AW'(2), 8'h77, 1'b0);
      rd(BASE + AW'(7), v);    chk("R1 ram write leaves clock", v, 8'h42);

      // R2 rdata holds through idle and write cycles
      rd(AW'(0), v);
      wr(AW'(5), 8'hEE, 1'b0);
      repeat (3) @(negedge clk);
      chk("R2 rdata held", rdata, 8'h3C);

      // R4..R9 table: park before a boundary, one tick, read all fields
      for (int i = 0; i < NV; i++) begin
         for (int k = 0; k < 8; k++) wr(BASE + AW'(k), VIN[i][63-8*k -: 8], 1'b0);
         pulse();
         for (int k = 0; k < 8; k++) begin
            rd(BASE + AW'(k), v);
            chk($sformatf("R%0d vector %0d offset %0d", VREQ[i], i, k),
                v, VEXP[i][63-8*k -: 8]);
         end
      end

      // R10 write and tick in the same cycle
      wr(BASE + AW'(6), 8'h10, 1'b0);
      wr(BASE + AW'(7), 8'h59, 1'b1);
      rd(BASE + AW'(7), v);    chk("R10 same-cycle tick seconds", v, 8'h00);
      rd(BASE + AW'(6), v);    chk("R10 same-cycle tick minutes", v, 8'h11);

      // R2 a clock read returns the value before its own edge's tick
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = BASE + AW'(7); tick = 1'b1;
      @(negedge clk);
      sel = 1'b0; tick = 1'b0;
      chk("R2 read sees pre-tick value", rdata, 8'h00);
      rd(BASE + AW'(7), v);    chk("R4 tick after read", v, 8'h01);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule